// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block carries out the architectural state change that happens when a register-windowed 32-bit processor takes a trap or an interrupt. A trap-request strobe arrives with an 8-bit trap type and a snapshot of the current program counter, next program counter, window pointer, supervisor and trap-enable bits, and the upper bits of the trap base register. One clock later the block presents the new state, together with a register-file write. That write stores the old PC and nPC into two locals of the freshly entered window.

When the trap is an external interrupt, the block also sends an acknowledge pulse to the interrupt controller. In the same cycle it can drive each cache from its enabled state to its frozen state, if that cache's freeze-on-interrupt control bit is set.

A trap that arrives while traps are disabled is fatal: the block latches a sticky error state and changes no architectural state. There is one exception. Trap type 0x80 with the shutdown option enabled raises a shutdown request instead. Choosing between competing traps, fetching instructions and the interrupt controller itself live elsewhere.

Top module: `trap_entry_seq`

## Requirements
- R1: During and after a synchronous reset, every output is zero: done, irq_ack, shutdown_req, err_state, the freeze pulses, rf_we and all held state outputs. The exceptions are rf_idx_a and rf_idx_b, which are constant.
- R2: A strobe with cur_ten=1 and no error latched is accepted. Exactly one clock later done pulses high for one cycle, with nxt_ten=0, nxt_sup=1 and nxt_psup equal to the cur_sup of the strobe cycle.
- R3: On an accepted trap, nxt_wp is cur_wp minus one, modulo 8 windows, so window 0 becomes window 7.
- R4: On an accepted trap, rf_we pulses with rf_wp equal to nxt_wp. Lane A writes cur_pc to register index 17 (rf_idx_a=17). Lane B writes cur_npc to register index 18 (rf_idx_b=18).
- R5: On an accepted trap, nxt_tbr is {tbr_base, trap_type, 4'h0}, where tbr_base supplies bits [31:12] and trap_type occupies bits [11:4]. nxt_pc equals nxt_tbr and nxt_npc equals nxt_tbr+4.
- R6: An accepted trap whose type lies in 0x11 to 0x1F pulses irq_ack together with done, and irq_ack_tt carries the trap type. Types 0x10, 0x20 and higher, and 0x00 to 0x0F, give no acknowledge.
- R7: Cache state encodings are 00 disabled, 01 frozen, 11 enabled. On an acknowledged interrupt, if ic_foi=1 and cache_state_in[1:0]=11, cache_state_out[1:0] becomes 01 and ic_freeze pulses. In every other case the field is copied unchanged and ic_freeze stays low.
- R8: The same rule applies to the data cache, using dc_foi, the field at bits [3:2] and dc_freeze. The two caches are decided independently.
- R9: A strobe with cur_ten=0 that is not the shutdown case sets err_state one clock later. It gives no done and leaves every held output unchanged. Only reset clears err_state.
- R10: A strobe with cur_ten=0, trap_type=0x80 and shutdown_en=1 pulses shutdown_req one clock later. It sets no error, gives no done and changes no held output. With any other type, or with shutdown_en=0, the R9 rule applies.
- R11: While err_state is high, every trap strobe is ignored: no done, no acknowledge, no shutdown, and every held output is unchanged.
- R12: Software trap types 0x80 to 0xFF taken with cur_ten=1 are accepted like any other trap, with the vector built from the trap type and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap request strobe |
| trap_type | input | 8 | Trap type of the request |
| cur_pc | input | 32 | Current program counter |
| cur_npc | input | 32 | Current next program counter |
| cur_wp | input | 3 | Current window pointer |
| cur_sup | input | 1 | Current supervisor bit |
| cur_ten | input | 1 | Current trap-enable bit |
| tbr_base | input | 20 | Trap base register bits [31:12] |
| shutdown_en | input | 1 | Turns trap 0x80 with traps disabled into a shutdown request |
| cache_state_in | input | 4 | Instruction cache state [1:0], data cache state [3:2] |
| ic_foi | input | 1 | Instruction cache freeze-on-interrupt enable |
| dc_foi | input | 1 | Data cache freeze-on-interrupt enable |
| done | output | 1 | One-cycle pulse when an accepted trap commits |
| nxt_pc | output | 32 | New program counter |
| nxt_npc | output | 32 | New next program counter |
| nxt_wp | output | 3 | New window pointer |
| nxt_sup | output | 1 | New supervisor bit |
| nxt_psup | output | 1 | New previous-supervisor bit |
| nxt_ten | output | 1 | New trap-enable bit |
| nxt_tbr | output | 32 | New trap base register |
| rf_we | output | 1 | Register-file write strobe, both lanes |
| rf_wp | output | 3 | Window written |
| rf_idx_a | output | 5 | Register index of lane A (17) |
| rf_data_a | output | 32 | Saved PC |
| rf_idx_b | output | 5 | Register index of lane B (18) |
| rf_data_b | output | 32 | Saved nPC |
| irq_ack | output | 1 | Interrupt acknowledge pulse |
| irq_ack_tt | output | 8 | Trap type of the last accepted trap |
| cache_state_out | output | 4 | Updated cache state fields |
| ic_freeze | output | 1 | Instruction cache freeze pulse |
| dc_freeze | output | 1 | Data cache freeze pulse |
| shutdown_req | output | 1 | Shutdown request pulse |
| err_state | output | 1 | Sticky error state |

## Verification
The interrupt acknowledge and the cache freezes fall in the same commit cycle as the state update. The bench provokes this with interrupt traps at both ends of the 0x11 to 0x1F range, using cache fields and freeze enables chosen so that both caches freeze, only one freezes, or neither does because its field is not enabled. A scoreboard item records, for that single cycle, the expected acknowledge, both freeze pulses and the merged cache field, so an ordering or cross-lane error shows up as a mismatch in one commit. Neighbouring types 0x10 and 0x20, a software trap, and the shutdown-versus-error split with traps disabled are judged the same way.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int XLEN     = 32;
    localparam int TT_W     = 8;
    localparam int NWIN_DEF = 8;
    localparam int BASE_LSB = 12;
    localparam int RIDX_W   = 5;

    localparam logic [RIDX_W-1:0] RF_IDX_PC  = 5'd17;
    localparam logic [RIDX_W-1:0] RF_IDX_NPC = 5'd18;
    localparam logic [TT_W-1:0]   TT_SHUTDOWN = 8'h80;

    typedef enum logic [1:0] {
        CST_OFF    = 2'b00,
        CST_FROZEN = 2'b01,
        CST_RSVD   = 2'b10,
        CST_ON     = 2'b11
    } cst_e;

    typedef struct packed {
        logic accept;
        logic to_error;
        logic shutdown;
        logic is_irq;
    } trap_cls_t;

    function automatic logic tt_is_irq(input logic [TT_W-1:0] tt);
        return (tt[7:4] == 4'h1) && (tt[3:0] != 4'h0);
    endfunction

    function automatic logic [XLEN-1:0] trap_vector(
        input logic [XLEN-1:BASE_LSB] base,
        input logic [TT_W-1:0]        tt
    );
        return {base, tt, 4'h0};
    endfunction

endpackage

// File: rtl/trap_decide.sv
module trap_decide
    import trap_entry_pkg::*;
(
    input  logic            trap_req,
    input  logic [TT_W-1:0] tt,
    input  logic            ten,
    input  logic            shutdown_en,
    input  logic            err_q,
    output trap_cls_t       cls
);
    logic live;
    logic sd;

    assign live = trap_req && !err_q;
    assign sd   = live && !ten && shutdown_en && (tt == TT_SHUTDOWN);

    always_comb begin
        cls.accept   = live && ten;
        cls.shutdown = sd;
        cls.to_error = live && !ten && !sd;
        cls.is_irq   = live && ten && tt_is_irq(tt);
    end

    always_comb begin
        if (trap_req) begin
            AST_ONE_OUTCOME: assert ($onehot0({cls.accept, cls.shutdown, cls.to_error})); // R9
        end
    end
endmodule

// File: rtl/trap_state_calc.sv
module trap_state_calc
    import trap_entry_pkg::*;
#(
    parameter int NWIN = NWIN_DEF,
    localparam int WPW = $clog2(NWIN)
) (
    input  logic [XLEN-1:BASE_LSB] base,
    input  logic [TT_W-1:0]        tt,
    input  logic [WPW-1:0]         wp,
    output logic [XLEN-1:0]        n_tbr,
    output logic [XLEN-1:0]        n_pc,
    output logic [XLEN-1:0]        n_npc,
    output logic [WPW-1:0]         n_wp
);
    localparam logic [WPW-1:0] WP_TOP = WPW'(NWIN - 1);

    always_comb begin
        n_tbr = trap_vector(base, tt);
        n_pc  = n_tbr;
        n_npc = n_tbr + XLEN'(4);
        n_wp  = (wp == '0) ? WP_TOP : wp - 1'b1;
    end
endmodule

// File: rtl/cache_freeze_ctl.sv
module cache_freeze_ctl
    import trap_entry_pkg::*;
#(
    parameter int NCACHE = 2,
    localparam int SW = 2 * NCACHE
) (
    input  logic              irq,
    input  logic [NCACHE-1:0] foi,
    input  logic [SW-1:0]     st_in,
    output logic [SW-1:0]     st_out,
    output logic [NCACHE-1:0] frz
);
    for (genvar c = 0; c < NCACHE; c++) begin : g_cache
        logic hit;
        assign hit = irq && foi[c] && (st_in[2*c +: 2] == CST_ON);
        assign st_out[2*c +: 2] = hit ? CST_FROZEN : st_in[2*c +: 2];
        assign frz[c] = hit;

        always_comb begin
            if (!irq) begin
                AST_NO_FREEZE_IDLE: assert (!frz[c] && st_out[2*c +: 2] == st_in[2*c +: 2]); // R7
            end
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int NWIN = NWIN_DEF,
    localparam int WPW = $clog2(NWIN)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trap_req,
    input  logic [TT_W-1:0]        trap_type,
    input  logic [XLEN-1:0]        cur_pc,
    input  logic [XLEN-1:0]        cur_npc,
    input  logic [WPW-1:0]         cur_wp,
    input  logic                   cur_sup,
    input  logic                   cur_ten,
    input  logic [XLEN-1:BASE_LSB] tbr_base,
    input  logic                   shutdown_en,
    input  logic [3:0]             cache_state_in,
    input  logic                   ic_foi,
    input  logic                   dc_foi,
    output logic                   done,
    output logic [XLEN-1:0]        nxt_pc,
    output logic [XLEN-1:0]        nxt_npc,
    output logic [WPW-1:0]         nxt_wp,
    output logic                   nxt_sup,
    output logic                   nxt_psup,
    output logic                   nxt_ten,
    output logic [XLEN-1:0]        nxt_tbr,
    output logic                   rf_we,
    output logic [WPW-1:0]         rf_wp,
    output logic [RIDX_W-1:0]      rf_idx_a,
    output logic [XLEN-1:0]        rf_data_a,
    output logic [RIDX_W-1:0]      rf_idx_b,
    output logic [XLEN-1:0]        rf_data_b,
    output logic                   irq_ack,
    output logic [TT_W-1:0]        irq_ack_tt,
    output logic [3:0]             cache_state_out,
    output logic                   ic_freeze,
    output logic                   dc_freeze,
    output logic                   shutdown_req,
    output logic                   err_state
);
    trap_cls_t         cls;
    logic [XLEN-1:0]   c_tbr, c_pc, c_npc;
    logic [WPW-1:0]    c_wp;
    logic [3:0]        c_cst;
    logic [1:0]        c_frz;

    trap_decide u_decide (
        .trap_req    (trap_req),
        .tt          (trap_type),
        .ten         (cur_ten),
        .shutdown_en (shutdown_en),
        .err_q       (err_state),
        .cls         (cls)
    );

    trap_state_calc #(.NWIN(NWIN)) u_calc (
        .base  (tbr_base),
        .tt    (trap_type),
        .wp    (cur_wp),
        .n_tbr (c_tbr),
        .n_pc  (c_pc),
        .n_npc (c_npc),
        .n_wp  (c_wp)
    );

    cache_freeze_ctl #(.NCACHE(2)) u_cache (
        .irq    (cls.is_irq),
        .foi    ({dc_foi, ic_foi}),
        .st_in  (cache_state_in),
        .st_out (c_cst),
        .frz    (c_frz)
    );

    assign rf_idx_a = RF_IDX_PC;
    assign rf_idx_b = RF_IDX_NPC;

    always_ff @(posedge clk) begin
        if (rst) begin
            done            <= 1'b0;
            nxt_pc          <= '0;
            nxt_npc         <= '0;
            nxt_wp          <= '0;
            nxt_sup         <= 1'b0;
            nxt_psup        <= 1'b0;
            nxt_ten         <= 1'b0;
            nxt_tbr         <= '0;
            rf_we           <= 1'b0;
            rf_wp           <= '0;
            rf_data_a       <= '0;
            rf_data_b       <= '0;
            irq_ack         <= 1'b0;
            irq_ack_tt      <= '0;
            cache_state_out <= '0;
            ic_freeze       <= 1'b0;
            dc_freeze       <= 1'b0;
            shutdown_req    <= 1'b0;
            err_state       <= 1'b0;
        end else begin
            done         <= 1'b0;
            rf_we        <= 1'b0;
            irq_ack      <= 1'b0;
            ic_freeze    <= 1'b0;
            dc_freeze    <= 1'b0;
            shutdown_req <= cls.shutdown;
            if (cls.to_error) begin
                err_state <= 1'b1;
            end
            if (cls.accept) begin
                done            <= 1'b1;
                nxt_pc          <= c_pc;
                nxt_npc         <= c_npc;
                nxt_wp          <= c_wp;
                nxt_sup         <= 1'b1;
                nxt_psup        <= cur_sup;
                nxt_ten         <= 1'b0;
                nxt_tbr         <= c_tbr;
                rf_we           <= 1'b1;
                rf_wp           <= c_wp;
                rf_data_a       <= cur_pc;
                rf_data_b       <= cur_npc;
                irq_ack         <= cls.is_irq;
                irq_ack_tt      <= trap_type;
                cache_state_out <= c_cst;
                ic_freeze       <= c_frz[0];
                dc_freeze       <= c_frz[1];
            end
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_state |=> err_state); // R9
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        err_state |=> (!done && !irq_ack && !shutdown_req)); // R11
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (trap_req && cur_ten && !err_state) |=> done); // R2
    AST_MODE_BITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (nxt_sup && !nxt_ten)); // R2
    AST_NPC_STEP: assert property (@(posedge clk) disable iff (rst)
        done |-> (nxt_npc == nxt_pc + XLEN'(4) && nxt_pc == nxt_tbr)); // R5
    AST_RF_WINDOW: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (done && rf_wp == nxt_wp)); // R4
    AST_ACK_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (done && irq_ack_tt[7:4] == 4'h1 && irq_ack_tt[3:0] != 4'h0)); // R6
    AST_FREEZE_ACK: assert property (@(posedge clk) disable iff (rst)
        (ic_freeze || dc_freeze) |-> irq_ack); // R7
    AST_SHUT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> (!done && !err_state)); // R10
endmodule

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_type = '0;
    logic [31:0] cur_pc = '0, cur_npc = '0;
    logic [2:0]  cur_wp = '0;
    logic        cur_sup = 1'b0, cur_ten = 1'b0;
    logic [19:0] tbr_base = '0;
    logic        shutdown_en = 1'b0;
    logic [3:0]  cache_state_in = '0;
    logic        ic_foi = 1'b0, dc_foi = 1'b0;

    logic        done, nxt_sup, nxt_psup, nxt_ten, rf_we, irq_ack;
    logic        ic_freeze, dc_freeze, shutdown_req, err_state;
    logic [31:0] nxt_pc, nxt_npc, nxt_tbr, rf_data_a, rf_data_b;
    logic [2:0]  nxt_wp, rf_wp;
    logic [4:0]  rf_idx_a, rf_idx_b;
    logic [7:0]  irq_ack_tt;
    logic [3:0]  cache_state_out;

    trap_entry_seq i_trap_entry_seq (.*);

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        string       req;
        logic        done, ack, shut, err, rfwe, icf, dcf;
        logic [31:0] pc, npc, tbr, da, db;
        logic [2:0]  wp, rfwp;
        logic        sup, psup, ten;
        logic [7:0]  acktt;
        logic [3:0]  cst;
    } exp_t;

    exp_t sb[$];

    logic        m_err, m_sup, m_psup, m_ten;
    logic [31:0] m_pc, m_npc, m_tbr, m_da, m_db;
    logic [2:0]  m_wp, m_rfwp;
    logic [7:0]  m_acktt;
    logic [3:0]  m_cst;

    task automatic model_reset();
        m_err = 0; m_sup = 0; m_psup = 0; m_ten = 0;
        m_pc = 0; m_npc = 0; m_tbr = 0; m_da = 0; m_db = 0;
        m_wp = 0; m_rfwp = 0; m_acktt = 0; m_cst = 0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: applies one strobe and pushes the expected commit-cycle outputs.
    task automatic fire(input string req, input logic [7:0] tt,
                        input logic [31:0] pc, input logic [31:0] npc,
                        input logic [2:0] wp, input logic sup, input logic ten,
                        input logic [19:0] tb, input logic sh,
                        input logic [3:0] cs, input logic ifo, input logic dfo);
        exp_t e;
        logic acc, sd, er, icf, dcf, ack;
        @(negedge clk);
        trap_req = 1; trap_type = tt; cur_pc = pc; cur_npc = npc; cur_wp = wp;
        cur_sup = sup; cur_ten = ten; tbr_base = tb; shutdown_en = sh;
        cache_state_in = cs; ic_foi = ifo; dc_foi = dfo;
        acc = !m_err && ten;
        sd  = !m_err && !ten && sh && (tt == 8'h80);
        er  = !m_err && !ten && !sd;
        ack = acc && (tt >= 8'h11) && (tt <= 8'h1F);
        icf = ack && ifo && (cs[1:0] == 2'b11);
        dcf = ack && dfo && (cs[3:2] == 2'b11);
        if (er) m_err = 1;
        if (acc) begin
            m_wp = (wp == 3'd0) ? 3'd7 : wp - 3'd1;
            m_tbr = {tb, tt, 4'h0};
            m_pc = m_tbr; m_npc = m_tbr + 32'd4;
            m_sup = 1; m_psup = sup; m_ten = 0;
            m_rfwp = m_wp; m_da = pc; m_db = npc; m_acktt = tt;
            m_cst = {dcf ? 2'b01 : cs[3:2], icf ? 2'b01 : cs[1:0]};
        end
        e.due = cyc + 1; e.req = req;
        e.done = acc; e.ack = ack; e.shut = sd; e.err = m_err; e.rfwe = acc;
        e.icf = icf; e.dcf = dcf;
        e.pc = m_pc; e.npc = m_npc; e.tbr = m_tbr; e.da = m_da; e.db = m_db;
        e.wp = m_wp; e.rfwp = m_rfwp; e.sup = m_sup; e.psup = m_psup;
        e.ten = m_ten; e.acktt = m_acktt; e.cst = m_cst;
        sb.push_back(e);
        @(negedge clk);
        trap_req = 0;
    endtask

    // Monitor: pops the item due in this cycle and compares every output.
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0 && sb[0].due == cyc) begin
            e = sb.pop_front();
            chk(e.req, "done (R2)", done, e.done);
            chk(e.req, "nxt_ten (R2)", nxt_ten, e.ten);
            chk(e.req, "nxt_sup (R2)", nxt_sup, e.sup);
            chk(e.req, "nxt_psup (R2)", nxt_psup, e.psup);
            chk(e.req, "nxt_wp (R3)", nxt_wp, e.wp);
            chk(e.req, "rf_we (R4)", rf_we, e.rfwe);
            chk(e.req, "rf_wp (R4)", rf_wp, e.rfwp);
            chk(e.req, "rf_data_a (R4)", rf_data_a, e.da);
            chk(e.req, "rf_data_b (R4)", rf_data_b, e.db);
            chk(e.req, "rf_idx_a (R4)", rf_idx_a, 32'd17);
            chk(e.req, "rf_idx_b (R4)", rf_idx_b, 32'd18);
            chk(e.req, "nxt_tbr (R5)", nxt_tbr, e.tbr);
            chk(e.req, "nxt_pc (R5)", nxt_pc, e.pc);
            chk(e.req, "nxt_npc (R5)", nxt_npc, e.npc);
            chk(e.req, "irq_ack (R6)", irq_ack, e.ack);
            chk(e.req, "irq_ack_tt (R6)", irq_ack_tt, e.acktt);
            chk(e.req, "cache_state_out (R7/R8)", cache_state_out, e.cst);
            chk(e.req, "ic_freeze (R7)", ic_freeze, e.icf);
            chk(e.req, "dc_freeze (R8)", dc_freeze, e.dcf);
            chk(e.req, "shutdown_req (R10)", shutdown_req, e.shut);
            chk(e.req, "err_state (R9)", err_state, e.err);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        // R1: reset state visible at the ports
        chk("R1", "done", done, 0);
        chk("R1", "err_state", err_state, 0);
        chk("R1", "irq_ack", irq_ack, 0);
        chk("R1", "shutdown_req", shutdown_req, 0);
        chk("R1", "rf_we", rf_we, 0);
        chk("R1", "nxt_pc", nxt_pc, 0);
        chk("R1", "nxt_tbr", nxt_tbr, 0);
        chk("R1", "cache_state_out", {28'd0, cache_state_out}, 0);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R2/R3: ordinary trap from user mode
        fire("R2", 8'h05, 32'h0000_1000, 32'h0000_1004, 3'd3, 0, 1,
             20'hABCDE, 0, 4'b0000, 0, 0);
        // R3: window 0 wraps to 7; 0x20 just above the interrupt range (R6)
        fire("R3", 8'h20, 32'h0000_2000, 32'h0000_2008, 3'd0, 1, 1,
             20'h12345, 0, 4'b1111, 1, 1);
        // R7/R8: lowest interrupt, both caches enabled and freezing
        fire("R8", 8'h11, 32'h4000_0000, 32'h4000_0004, 3'd5, 0, 1,
             20'h00040, 0, 4'b1111, 1, 1);
        // R7: highest interrupt, only instruction cache freezes
        fire("R7", 8'h1F, 32'h4000_0100, 32'h4000_0104, 3'd1, 1, 1,
             20'hFFFFF, 0, 4'b1111, 1, 0);
        // R8: data cache alone, instruction field frozen already
        fire("R8", 8'h1A, 32'h4000_0200, 32'h4000_0204, 3'd7, 1, 1,
             20'h00001, 0, 4'b1101, 1, 1);
        // R7: fields disabled/frozen are not touched
        fire("R7", 8'h13, 32'h4000_0300, 32'h4000_0304, 3'd2, 0, 1,
             20'h00002, 0, 4'b0100, 1, 1);
        // R6: 0x10 is not an interrupt, no freeze
        fire("R6", 8'h10, 32'h5000_0000, 32'h5000_0004, 3'd4, 1, 1,
             20'h00003, 0, 4'b1111, 1, 1);
        // R12: software trap 0xFF with traps enabled
        fire("R12", 8'hFF, 32'h6000_0000, 32'h6000_0010, 3'd6, 1, 1,
             20'h77777, 1, 4'b1111, 1, 1);
        // R12: software trap 0x80 with traps enabled is not a shutdown
        fire("R12", 8'h80, 32'h6000_0100, 32'h6000_0104, 3'd1, 0, 1,
             20'h0ABCD, 1, 4'b0011, 1, 1);
        // R10: shutdown with traps disabled
        fire("R10", 8'h80, 32'h7000_0000, 32'h7000_0004, 3'd2, 1, 0,
             20'h11111, 1, 4'b1111, 1, 1);
        // R9: 0x80 without the shutdown option -> error
        fire("R9", 8'h80, 32'h7000_0100, 32'h7000_0104, 3'd2, 1, 0,
             20'h22222, 0, 4'b1111, 1, 1);
        // R11: traps ignored in error state
        fire("R11", 8'h12, 32'h7000_0200, 32'h7000_0204, 3'd5, 0, 1,
             20'h33333, 0, 4'b1111, 1, 1);
        fire("R11", 8'h80, 32'h7000_0300, 32'h7000_0304, 3'd5, 0, 0,
             20'h33333, 1, 4'b1111, 1, 1);
        repeat (3) @(negedge clk);
        chk("R9", "err_state held", err_state, 1);
        do_reset();
        // R10: 0x81 with traps disabled is an error even with shutdown set
        fire("R10", 8'h81, 32'h8000_0000, 32'h8000_0004, 3'd3, 0, 0,
             20'h44444, 1, 4'b0000, 0, 0);
        do_reset();
        // R2: accepted again after reset, from supervisor mode
        fire("R2", 8'h09, 32'h9000_0000, 32'h9000_0004, 3'd1, 1, 1,
             20'h55555, 0, 4'b0000, 0, 0);
        repeat (4) @(negedge clk);
        chk("R2", "scoreboard drained", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule